// File: doc/BRIEF.md
# Leap-Forward Multi-Bit LFSR Generator

This block is a pseudo-random word source built around a shift register with linear feedback. Each serial step moves the state up by one place and places the parity of a chosen set of state bits into bit 0. A register that makes one such step per clock produces words that are mostly the previous word shifted by one place. This design instead computes several serial steps in combinational logic and registers the result in a single cycle. With the default leap count, every bit of each output word is new.

The feedback set is a hexadecimal mask parameter. Its highest set bit is the feedback point, and that bit sets the effective register length. The default is a 30-bit register whose feedback is the parity of bits 29, 5, 3 and 0. The register may be wider than the output word, which gives a longer period; the word is then taken from the low state bits.

A reset, an enable-gated advance and a run-time reseed are the only controls. A zero seed is never allowed into the register. If the register ever holds zero, the next clock loads all ones.

Top module: `lfsr_leap_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state loads the parameter `SEED`. A zero `SEED` loads all ones instead. `rand_out` always shows state bits `[OUT_W-1:0]`.
- R2: On each clock edge where the block is running, `step_en` is high and `seed_load` is low, the state advances exactly `STEPS` serial steps. One serial step is `s <= {s[STATE_W-2:0], ^(s & TAP_MASK)}`.
- R3: With `STEPS` = 1, the output sequence is identical to that of a plain serial LFSR with one step per clock.
- R4: With `step_en` and `seed_load` both low, the state and `rand_out` do not change.
- R5: `seed_load` high loads `seed_val` into the state at the next edge. It takes priority over `step_en`.
- R6: A `seed_val` of zero loaded by `seed_load` becomes all ones.
- R7: After reset, the state is never all zeros.
- R8: A maximal tap set with N state bits returns to its start state after exactly 2^N − 1 single steps. For example, a 5-bit register with mask 0x12 has a period of 31.
- R9: When `STATE_W` exceeds `OUT_W`, the full state advances, and the output is the low `OUT_W` bits of that state.
- R10: The default mask 0x20000029 on a 30-bit register draws its feedback from bits 29, 5, 3 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; loads `SEED` |
| step_en | input | 1 | Advance the state by `STEPS` serial steps this clock |
| seed_load | input | 1 | Load `seed_val` this clock (has priority over `step_en`) |
| seed_val | input | STATE_W | Run-time seed; zero is replaced by all ones |
| rand_out | output | OUT_W | Low `OUT_W` bits of the registered state |

## Verification
The hardest thing to reach from the ports is the return to the start state after a full period. It needs a long, unbroken run of single steps from a known seed, and any reseed or stall along the way ruins the count. The bench therefore builds a 5-bit single-step instance and, after a fresh reset, steps it continuously while counting cycles until the seed value reappears. The zero-seed replacement is reached on purpose by loading zero through `seed_load` in both directed and random phases. Random enable and reseed traffic runs on a default instance and on a 31-bit instance whose output is one bit narrower than its state. Every word from these instances is compared with a bench model that applies the serial step the required number of times.

// File: rtl/lfsr_leap_pkg.sv
// Package: shared types for the leap-forward LFSR generator.
// Assumes: nothing beyond standard SystemVerilog.
package lfsr_leap_pkg;

    // Source selected for the next register value.
    typedef enum logic [1:0] {
        SRC_HOLD    = 2'd0,
        SRC_LOAD    = 2'd1,
        SRC_RECOVER = 2'd2,
        SRC_ADVANCE = 2'd3
    } lfsr_src_e;

endpackage

// File: rtl/lfsr_leap_unroll.sv
// Module: lfsr_leap_unroll
// Computes STEPS serial LFSR steps in pure combinational logic.
// One step shifts the word up one place and inserts the parity of the
// masked bits at bit 0.
// Assumes: 1 <= STEPS, W >= 2, the mask's top set bit is the feedback point.
module lfsr_leap_unroll #(
    parameter int          W     = 30,
    parameter logic [W-1:0] MASK = '1,
    parameter int          STEPS = 30
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    logic [W-1:0] stage [STEPS+1];

    // Chain entry: the present state.
    assign stage[0] = cur;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic fb;
        // Feedback bit for this step.
        assign fb = ^(stage[i] & MASK);
        // Shift up and insert the feedback.
        assign stage[i+1] = {stage[i][W-2:0], fb};
    end

    // Chain exit: the state after STEPS steps.
    assign nxt = stage[STEPS];

endmodule

// File: rtl/lfsr_seed_fix.sv
// Module: lfsr_seed_fix
// Replaces an all-zero seed with all ones, so that the lock-up state
// never reaches the register.
// Assumes: any nonzero seed is acceptable as is.
module lfsr_seed_fix #(
    parameter int W = 30
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] safe
);

    // Substitute all ones for zero.
    always_comb begin
        if (raw == '0) safe = '1;
        else           safe = raw;
    end

endmodule

// File: rtl/lfsr_leap_ctrl.sv
// Module: lfsr_leap_ctrl
// Picks the source of the next state.
// Priority: run-time load, then zero recovery, then advance, then hold.
// Assumes: reset is applied by the register stage, not here.
module lfsr_leap_ctrl
    import lfsr_leap_pkg::*;
(
    input  logic      seed_load,
    input  logic      step_en,
    input  logic      state_zero,
    output lfsr_src_e src
);

    // Fixed-priority source choice.
    always_comb begin
        if (seed_load)       src = SRC_LOAD;
        else if (state_zero) src = SRC_RECOVER;
        else if (step_en)    src = SRC_ADVANCE;
        else                 src = SRC_HOLD;
    end

endmodule

// File: rtl/lfsr_leap_gen.sv
// Module: lfsr_leap_gen (top)
// Leap-forward Fibonacci LFSR: each enabled clock advances STEPS serial
// steps at once, so the output words are not simple shifts of each other.
// Assumes: synchronous active-low reset; 1 <= STEPS <= STATE_W;
// OUT_W <= STATE_W; TAP_MASK has bit STATE_W-1 set for full length.
module lfsr_leap_gen
    import lfsr_leap_pkg::*;
#(
    parameter int                 STATE_W  = 30,
    parameter logic [STATE_W-1:0] TAP_MASK = 30'h20000029,
    parameter int                 OUT_W    = 30,
    parameter int                 STEPS    = OUT_W,
    parameter logic [STATE_W-1:0] SEED     = 30'h0BADF00D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               seed_load,
    input  logic [STATE_W-1:0] seed_val,
    output logic [OUT_W-1:0]   rand_out
);

    localparam logic [STATE_W-1:0] SEED_SAFE = (SEED == '0) ? '1 : SEED;

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;
    logic [STATE_W-1:0] leap_val;
    logic [STATE_W-1:0] load_val;
    logic               state_zero;
    lfsr_src_e          src;

    // Zero detect for lock-up recovery.
    assign state_zero = (state_q == '0);

    lfsr_leap_unroll #(
        .W     (STATE_W),
        .MASK  (TAP_MASK),
        .STEPS (STEPS)
    ) u_unroll (
        .cur (state_q),
        .nxt (leap_val)
    );

    lfsr_seed_fix #(
        .W (STATE_W)
    ) u_seed_fix (
        .raw  (seed_val),
        .safe (load_val)
    );

    lfsr_leap_ctrl u_ctrl (
        .seed_load  (seed_load),
        .step_en    (step_en),
        .state_zero (state_zero),
        .src        (src)
    );

    // Next-state multiplexer.
    always_comb begin
        unique case (src)
            SRC_LOAD:    state_d = load_val;
            SRC_RECOVER: state_d = '1;
            SRC_ADVANCE: state_d = leap_val;
            default:     state_d = state_q;
        endcase
    end

    // State register with synchronous reset to the seed.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED_SAFE;
        else        state_q <= state_d;
    end

    // Output word from the low state bits.
    assign rand_out = state_q[OUT_W-1:0];

endmodule

// File: rtl/lfsr_leap_gen_chk.sv
// Module: lfsr_leap_gen_chk
// Temporal checks on the leap-forward LFSR, bound to every instance.
// Assumes: the bound instance exposes its state register as state_q.
module lfsr_leap_gen_chk #(
    parameter int                 STATE_W = 30,
    parameter logic [STATE_W-1:0] SEED    = '1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step_en,
    input logic               seed_load,
    input logic [STATE_W-1:0] seed_val,
    input logic [STATE_W-1:0] state_q
);

    localparam logic [STATE_W-1:0] SEED_SAFE = (SEED == '0) ? '1 : SEED;

    logic past_valid = 1'b0;
    logic seen_rst   = 1'b0;

    // Mark that at least one edge has passed.
    always_ff @(posedge clk) past_valid <= 1'b1;

    // Mark that reset has been applied at least once.
    always_ff @(posedge clk) if (!rst_n) seen_rst <= 1'b1;

    // R1
    reset_seed_chk: assert property (@(posedge clk)
        past_valid && !$past(rst_n) |-> state_q == SEED_SAFE);

    // R5 R6
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(rst_n) && $past(seed_load)
        |-> state_q == (($past(seed_val) == '0) ? {STATE_W{1'b1}} : $past(seed_val)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(rst_n) && !$past(seed_load) && !$past(step_en)
        && ($past(state_q) != '0) |-> $stable(state_q));

    // R7
    nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst |-> state_q != '0);

endmodule

bind lfsr_leap_gen lfsr_leap_gen_chk #(
    .STATE_W (STATE_W),
    .SEED    (SEED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .state_q   (state_q)
);

// File: tb/lfsr_leap_gen_bench.sv
`timescale 1ns/1ps
module lfsr_leap_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        seed_load = 1'b0;
    logic [31:0] seed_raw = '0;

    logic [29:0] out_a;
    logic [4:0]  out_b;
    logic [29:0] out_c;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] m_a, m_b, m_c;

    localparam logic [31:0] SEED_A = 32'h0BADF00D;
    localparam logic [31:0] SEED_B = 32'h00000001;
    localparam logic [31:0] SEED_C = 32'h00000001;
    localparam logic [31:0] MASK_A = 32'h20000029;
    localparam logic [31:0] MASK_B = 32'h00000012;
    localparam logic [31:0] MASK_C = 32'h48000000;

    always #5 clk = ~clk;

    // Default: 30-bit, leap 30, output 30 (R2, R10).
    lfsr_leap_gen u_lfsr_leap_gen (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .seed_load(seed_load),
        .seed_val(seed_raw[29:0]), .rand_out(out_a)
    );

    // 5-bit single-step instance (R3, R8).
    lfsr_leap_gen #(
        .STATE_W(5), .TAP_MASK(5'h12), .OUT_W(5), .STEPS(1), .SEED(5'h01)
    ) u_lfsr_leap_gen_small (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .seed_load(seed_load),
        .seed_val(seed_raw[4:0]), .rand_out(out_b)
    );

    // 31-bit state, 30-bit output (R9).
    lfsr_leap_gen #(
        .STATE_W(31), .TAP_MASK(31'h48000000), .OUT_W(30), .STEPS(30), .SEED(31'h1)
    ) u_lfsr_leap_gen_wide (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .seed_load(seed_load),
        .seed_val(seed_raw[30:0]), .rand_out(out_c)
    );

    // Reference: k serial steps on a w-bit register.
    function automatic logic [31:0] leap(logic [31:0] s, logic [31:0] mask, int w, int k);
        logic [31:0] wm = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        for (int i = 0; i < k; i++) begin
            logic fb = ^(s & mask);
            s = ((s << 1) | {31'b0, fb}) & wm;
        end
        return s;
    endfunction

    function automatic logic [31:0] fix(logic [31:0] s, int w);
        logic [31:0] wm = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        return ((s & wm) == 0) ? wm : (s & wm);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Update the models for the inputs about to be sampled.
    task automatic model_edge();
        if (!rst_n) begin
            m_a = SEED_A; m_b = SEED_B; m_c = SEED_C;
        end else if (seed_load) begin
            m_a = fix(seed_raw, 30); m_b = fix(seed_raw, 5); m_c = fix(seed_raw, 31);
        end else if (step_en) begin
            m_a = leap(m_a, MASK_A, 30, 30);
            m_b = leap(m_b, MASK_B, 5, 1);
            m_c = leap(m_c, MASK_C, 31, 30);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " R2 R10 default"}, {2'b0, out_a}, m_a);
        check({tag, " R3 serial"},      {27'b0, out_b}, m_b);
        check({tag, " R9 wide"},        {2'b0, out_c}, m_c & 32'h3FFF_FFFF);
    endtask

    // One cycle: set inputs at negedge, let the edge pass, compare.
    task automatic cycle(logic en, logic ld, logic [31:0] sv, logic rn, string tag);
        step_en = en; seed_load = ld; seed_raw = sv; rst_n = rn;
        model_edge();
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        int seed_fixed = 7;
        void'($urandom(seed_fixed));
        @(negedge clk);
        cycle(0, 0, 0, 0, "R1 reset");
        cycle(0, 0, 0, 0, "R1 reset");
        check("R1 reset seed", {2'b0, out_a}, SEED_A);
        // Directed corner cases.
        cycle(1, 0, 0, 1, "R2 first leap");
        check("R10 taps 29,5,3,0", {2'b0, out_a}, leap(SEED_A, 32'h20000029, 30, 30));
        cycle(0, 0, 0, 1, "R4 hold");
        cycle(0, 0, 0, 1, "R4 hold");
        cycle(1, 1, 32'h0, 1, "R6 zero seed");
        check("R6 zero seed to ones", {27'b0, out_b}, 32'h1F);
        cycle(1, 1, 32'h12345678, 1, "R5 load over step");
        cycle(1, 0, 0, 1, "R2 after load");
        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            logic        en = r[0] | r[1];
            logic        ld = (r[5:2] == 4'h0);
            logic [31:0] sv = (r[8:6] == 3'h0) ? 32'h0 : $urandom;
            logic        rn = (r[15:9] != 7'h0);
            cycle(en, ld, sv, rn, "rand");
            if (rn && out_a == 30'h0) check("R7 nonzero", 32'h0, 32'h1);
        end
        // Period of the 5-bit single-step instance.
        cycle(0, 0, 0, 0, "R1 reset");
        begin
            int cnt = 0;
            step_en = 1; seed_load = 0; rst_n = 1;
            do begin
                @(negedge clk);
                cnt++;
                if (out_b == 5'h0) check("R7 small nonzero", 32'h0, 32'h1);
            end while (out_b != 5'h01 && cnt < 64);
            check("R8 period 31", cnt, 31);
        end
        summary();
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

endmodule